// File: doc/BRIEF.md
# Windowed Buffer Subset Gather

This block gives each of several channels a private local buffer of up to 512 data words and a gather engine that reads from it. A load phase writes words into a chosen channel's buffer and then declares the buffer loaded. A gather phase is launched with a configuration (index width, window base, window mask, miss policy, fill value, release flag, active channel count and element count), after which one index per channel is accepted on each beat of a linear index stream, and one output element per channel is produced for each accepted beat.

Every index is first narrowed to the configured unsigned width. It is then tested against the loaded window: the index lies inside the window when the bits outside the mask equal the window base, and the bits inside the mask select the buffer word. Inside the window the buffered word is written out. Outside it, the miss policy either writes the fill value or suppresses the write, so that a grouped gather can run several passes over different windows. The first pass fills every slot, and later passes overwrite only the slots they hit. Each output element carries its own write enable.

A configuration that breaks a rule is rejected without starting. A gather launched with no buffer loaded still runs, reports an error and treats every index as a miss.

Top module: `subset_gather`

## Requirements
- R1: A load beat writes `ld_data` into word `ld_addr` of the buffer of channel `ld_chan`. A `ld_done` pulse marks the buffers as loaded.
- R2: After narrowing, an index hits when `(index & ~cfg_win_mask) == cfg_win_base`. The buffer word read on a hit is given by the low 9 bits of `index & cfg_win_mask`.
- R3: On a hit the lane drives its `out_we` bit to 1 and places the addressed buffer word on its slice of `out_data`.
- R4: On a miss with `cfg_miss_skip` = 0 the lane drives `out_we` to 1 and outputs `cfg_fill`.
- R5: On a miss with `cfg_miss_skip` = 1 the lane drives `out_we` to 0 and its data slice to zero, so the destination is left untouched.
- R6: `cfg_idx_kind` selects the index width: 0 for unsigned 8-bit, 1 for unsigned 16-bit and 2 for unsigned 32-bit. The upper index bits are ignored and the index is zero-extended. Code 3 is rejected: `cfg_err` pulses one cycle after `g_start`, no gather starts and later index beats produce no output.
- R7: A configuration is also rejected when `cfg_miss_skip` = 1 with a nonzero `cfg_fill`, or when `cfg_count` = 0.
- R8: `cfg_act_ch` must lie between 1 and the channel count (at most 128), otherwise the configuration is rejected. Lanes numbered at or above `cfg_act_ch` keep `out_we` at 0.
- R9: Every index beat accepted while `busy` gives exactly one `out_valid` beat in the following cycle, so the output element count equals the index count. `done` is asserted together with the output of beat `cfg_count`, and `busy` is low from that cycle on.
- R10: With `cfg_release` = 1 the buffers are no longer loaded after the gather completes. With `cfg_release` = 0 they stay loaded for further gathers.
- R11: When a valid gather starts while no buffer is loaded, `no_buf_err` pulses together with the rise of `busy`, the gather runs, and every index is treated as a miss.
- R12: A `g_start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Buffer write strobe |
| ld_chan | input | CH_W | Channel whose buffer is written |
| ld_addr | input | 9 | Buffer word address |
| ld_data | input | DATA_W | Word to store |
| ld_done | input | 1 | Marks buffers loaded |
| g_start | input | 1 | Launch a gather with the cfg_* values |
| cfg_idx_kind | input | 2 | Index width code |
| cfg_win_base | input | 32 | Window base index |
| cfg_win_mask | input | 32 | Window offset mask |
| cfg_miss_skip | input | 1 | 0 writes the fill on a miss, 1 skips the write |
| cfg_fill | input | DATA_W | Fill value for misses |
| cfg_release | input | 1 | Free the buffers after this gather |
| cfg_act_ch | input | 8 | Active channel count |
| cfg_count | input | 16 | Index beats in the gather |
| idx_valid | input | 1 | Index beat present |
| idx_data | input | NUM_CH*32 | One raw index per channel |
| busy | output | 1 | Gather in progress |
| cfg_err | output | 1 | Configuration rejected (pulse) |
| no_buf_err | output | 1 | Gather launched without a loaded buffer (pulse) |
| out_valid | output | 1 | Output beat present |
| out_we | output | NUM_CH | Per-channel write enable |
| out_data | output | NUM_CH*DATA_W | Per-channel output element |
| done | output | 1 | Final output beat |

## Verification
`g_start` is registered once, so `busy`, `cfg_err` and `no_buf_err` are due in the cycle after the launch edge. Each index beat passes through one register stage together with a synchronous buffer read, so its `out_valid`, `out_we` and `out_data`, and `done` for the last beat, are due in the cycle after the edge that accepts it. The bench drives on the falling edge and samples on the next falling edge, which is exactly one rising edge later. It checks `busy` low on the falling edge after `done`, and checks R10 and R11 through the error pulse and the outputs of the following gather.

// File: rtl/sg_pkg.sv
package sg_pkg;

    localparam int IDX_W  = 32;
    localparam int CNT_W  = 16;
    localparam int ACT_W  = 8;
    localparam int MAX_CH = 128;

    typedef enum logic [1:0] {
        IDX_U8  = 2'd0,
        IDX_U16 = 2'd1,
        IDX_U32 = 2'd2,
        IDX_BAD = 2'd3
    } idx_kind_e;

    typedef struct packed {
        idx_kind_e          kind;
        logic [IDX_W-1:0]   win_base;
        logic [IDX_W-1:0]   win_mask;
        logic               miss_skip;
        logic               release_buf;
        logic [ACT_W-1:0]   act_ch;
        logic [CNT_W-1:0]   count;
    } gather_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    function automatic logic [IDX_W-1:0] narrow_index(idx_kind_e k, logic [IDX_W-1:0] raw);
        logic [IDX_W-1:0] r;
        case (k)
            IDX_U8:  r = {24'd0, raw[7:0]};
            IDX_U16: r = {16'd0, raw[15:0]};
            default: r = raw;
        endcase
        return r;
    endfunction

    function automatic logic cfg_legal(gather_cfg_t c, logic fill_nonzero, logic [ACT_W-1:0] ch_limit);
        logic ok;
        ok = (c.kind != IDX_BAD);
        ok = ok && !(c.miss_skip && fill_nonzero);
        ok = ok && (c.count != '0);
        ok = ok && (c.act_ch != '0) && (c.act_ch <= ch_limit);
        return ok;
    endfunction

endpackage

// File: rtl/sg_ctrl.sv
module sg_ctrl
    import sg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  gather_cfg_t       cfg_in,
    input  logic [DATA_W-1:0] fill_in,
    input  logic              idx_valid,
    input  logic              ld_done,
    output gather_cfg_t       cfg_q,
    output logic [DATA_W-1:0] fill_q,
    output logic              busy,
    output logic              accept,
    output logic              force_miss,
    output logic              cfg_err,
    output logic              no_buf_err,
    output logic              out_valid,
    output logic              done
);

    localparam logic [ACT_W-1:0] CH_LIMIT = ACT_W'(NUM_CH);

    run_state_e       state_q;
    logic [CNT_W-1:0] beat_q;
    logic             loaded_q;
    logic             launch;
    logic             legal;
    logic             last_beat;

    assign legal     = cfg_legal(cfg_in, |fill_in, CH_LIMIT);
    assign launch    = start && (state_q == ST_IDLE);
    assign accept    = (state_q == ST_RUN) && idx_valid;
    assign last_beat = accept && (beat_q == cfg_q.count - CNT_W'(1));
    assign busy      = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            beat_q     <= '0;
            cfg_q      <= '0;
            fill_q     <= '0;
            force_miss <= 1'b0;
            cfg_err    <= 1'b0;
            no_buf_err <= 1'b0;
        end else begin
            cfg_err    <= launch && !legal;
            no_buf_err <= launch && legal && !loaded_q;
            if (launch && legal) begin
                state_q    <= ST_RUN;
                beat_q     <= '0;
                cfg_q      <= cfg_in;
                fill_q     <= fill_in;
                force_miss <= !loaded_q;
            end else if (last_beat) begin
                state_q <= ST_IDLE;
            end else if (accept) begin
                beat_q <= beat_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            loaded_q <= 1'b0;
        end else if (ld_done) begin
            loaded_q <= 1'b1;
        end else if (last_beat && cfg_q.release_buf) begin
            loaded_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            out_valid <= accept;
            done      <= last_beat;
        end
    end

endmodule

// File: rtl/sg_lane.sv
module sg_lane
    import sg_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_we,
    input  logic [AW-1:0]     ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              accept,
    input  logic [IDX_W-1:0]  idx_raw,
    input  gather_cfg_t       cfg,
    input  logic [DATA_W-1:0] fill,
    input  logic              lane_on,
    input  logic              force_miss,
    output logic              we,
    output logic [DATA_W-1:0] data
);

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic [IDX_W-1:0]  idx_n;
    logic [AW-1:0]     offset;
    logic              hit_c;
    logic              hit_q;
    logic              wr_q;

    assign idx_n  = narrow_index(cfg.kind, idx_raw);
    assign hit_c  = !force_miss && ((idx_n & ~cfg.win_mask) == cfg.win_base);
    assign offset = AW'(idx_n & cfg.win_mask);

    always_ff @(posedge clk) begin
        if (ld_we) begin
            store[ld_addr] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            rd_q <= store[offset];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            wr_q  <= 1'b0;
        end else if (accept) begin
            hit_q <= hit_c;
            wr_q  <= lane_on && (hit_c || !cfg.miss_skip);
        end else begin
            hit_q <= 1'b0;
            wr_q  <= 1'b0;
        end
    end

    always_comb begin
        if (!wr_q) begin
            data = '0;
        end else if (hit_q) begin
            data = rd_q;
        end else begin
            data = fill;
        end
    end

    assign we = wr_q;

endmodule

// File: rtl/subset_gather.sv
module subset_gather
    import sg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    parameter int AW     = $clog2(DEPTH),
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_valid,
    input  logic [CH_W-1:0]          ld_chan,
    input  logic [AW-1:0]            ld_addr,
    input  logic [DATA_W-1:0]        ld_data,
    input  logic                     ld_done,
    input  logic                     g_start,
    input  logic [1:0]               cfg_idx_kind,
    input  logic [IDX_W-1:0]         cfg_win_base,
    input  logic [IDX_W-1:0]         cfg_win_mask,
    input  logic                     cfg_miss_skip,
    input  logic [DATA_W-1:0]        cfg_fill,
    input  logic                     cfg_release,
    input  logic [ACT_W-1:0]         cfg_act_ch,
    input  logic [CNT_W-1:0]         cfg_count,
    input  logic                     idx_valid,
    input  logic [NUM_CH*IDX_W-1:0]  idx_data,
    output logic                     busy,
    output logic                     cfg_err,
    output logic                     no_buf_err,
    output logic                     out_valid,
    output logic [NUM_CH-1:0]        out_we,
    output logic [NUM_CH*DATA_W-1:0] out_data,
    output logic                     done
);

    gather_cfg_t       cfg_in;
    gather_cfg_t       cfg_q;
    logic [DATA_W-1:0] fill_q;
    logic              accept;
    logic              force_miss;

    always_comb begin
        cfg_in             = '0;
        cfg_in.kind        = idx_kind_e'(cfg_idx_kind);
        cfg_in.win_base    = cfg_win_base;
        cfg_in.win_mask    = cfg_win_mask;
        cfg_in.miss_skip   = cfg_miss_skip;
        cfg_in.release_buf = cfg_release;
        cfg_in.act_ch      = cfg_act_ch;
        cfg_in.count       = cfg_count;
    end

    sg_ctrl #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (g_start),
        .cfg_in     (cfg_in),
        .fill_in    (cfg_fill),
        .idx_valid  (idx_valid),
        .ld_done    (ld_done),
        .cfg_q      (cfg_q),
        .fill_q     (fill_q),
        .busy       (busy),
        .accept     (accept),
        .force_miss (force_miss),
        .cfg_err    (cfg_err),
        .no_buf_err (no_buf_err),
        .out_valid  (out_valid),
        .done       (done)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        logic lane_on;
        logic lane_ld;

        assign lane_on = (cfg_q.act_ch > ACT_W'(g));
        assign lane_ld = ld_valid && (ld_chan == CH_W'(g));

        sg_lane #(
            .DEPTH  (DEPTH),
            .DATA_W (DATA_W),
            .AW     (AW)
        ) u_lane (
            .clk        (clk),
            .rst        (rst),
            .ld_we      (lane_ld),
            .ld_addr    (ld_addr),
            .ld_data    (ld_data),
            .accept     (accept),
            .idx_raw    (idx_data[g*IDX_W +: IDX_W]),
            .cfg        (cfg_q),
            .fill       (fill_q),
            .lane_on    (lane_on),
            .force_miss (force_miss),
            .we         (out_we[g]),
            .data       (out_data[g*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/subset_gather_chk.sv
module subset_gather_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              g_start,
    input logic              idx_valid,
    input logic              busy,
    input logic              cfg_err,
    input logic              no_buf_err,
    input logic              out_valid,
    input logic [NUM_CH-1:0] out_we,
    input logic              done
);

    // R9
    out_follows_idx_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(idx_valid) && $past(busy));

    // R9
    done_with_beat_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> out_valid);

    // R9
    idle_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    reject_no_run_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy && !no_buf_err && $past(g_start));

    // R11
    nobuf_runs_chk: assert property (@(posedge clk) disable iff (rst)
        no_buf_err |-> busy && $rose(busy));

    // R3
    we_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (out_we != '0) |-> out_valid);

endmodule

bind subset_gather subset_gather_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .g_start    (g_start),
    .idx_valid  (idx_valid),
    .busy       (busy),
    .cfg_err    (cfg_err),
    .no_buf_err (no_buf_err),
    .out_valid  (out_valid),
    .out_we     (out_we),
    .done       (done)
);

// File: tb/sim_subset_gather.sv
module sim_subset_gather;

    localparam int  NCH    = 4;
    localparam int  DEP    = 512;
    localparam int  DW     = 32;
    localparam time TCLK   = 10ns;

    logic            clk = 1'b0;
    logic            rst;
    logic            ld_valid;
    logic [1:0]      ld_chan;
    logic [8:0]      ld_addr;
    logic [DW-1:0]   ld_data;
    logic            ld_done;
    logic            g_start;
    logic [1:0]      cfg_idx_kind;
    logic [31:0]     cfg_win_base;
    logic [31:0]     cfg_win_mask;
    logic            cfg_miss_skip;
    logic [DW-1:0]   cfg_fill;
    logic            cfg_release;
    logic [7:0]      cfg_act_ch;
    logic [15:0]     cfg_count;
    logic            idx_valid;
    logic [NCH*32-1:0] idx_data;
    logic            busy, cfg_err, no_buf_err, out_valid, done;
    logic [NCH-1:0]  out_we;
    logic [NCH*DW-1:0] out_data;

    int n_chk  = 0;
    int n_fail = 0;

    logic [1:0]  m_kind;
    logic [31:0] m_base, m_mask, m_fill;
    logic        m_skip, m_nobuf;
    int          m_act;

    always #(TCLK/2) clk = ~clk;

    subset_gather #(.NUM_CH(NCH), .DEPTH(DEP), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_chan(ld_chan), .ld_addr(ld_addr),
        .ld_data(ld_data), .ld_done(ld_done), .g_start(g_start), .cfg_idx_kind(cfg_idx_kind),
        .cfg_win_base(cfg_win_base), .cfg_win_mask(cfg_win_mask), .cfg_miss_skip(cfg_miss_skip),
        .cfg_fill(cfg_fill), .cfg_release(cfg_release), .cfg_act_ch(cfg_act_ch),
        .cfg_count(cfg_count), .idx_valid(idx_valid), .idx_data(idx_data), .busy(busy),
        .cfg_err(cfg_err), .no_buf_err(no_buf_err), .out_valid(out_valid), .out_we(out_we),
        .out_data(out_data), .done(done)
    );

    function automatic logic [31:0] pat(int ch, int a);
        return 32'hC000_0000 + 32'(ch) * 32'h0010_0000 + 32'(a) * 32'h0000_0101;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // R1: fill every buffer with a known pattern, then mark loaded
    task automatic load_all();
        for (int c = 0; c < NCH; c++) begin
            for (int a = 0; a < DEP; a++) begin
                @(negedge clk);
                ld_valid = 1'b1; ld_chan = 2'(c); ld_addr = 9'(a); ld_data = pat(c, a);
            end
        end
        @(negedge clk);
        ld_valid = 1'b0; ld_done = 1'b1;
        @(negedge clk);
        ld_done = 1'b0;
    endtask

    task automatic launch(input logic [1:0] kind, input logic [31:0] base, input logic [31:0] mask,
                          input logic skip, input logic [31:0] fill, input logic rel,
                          input int act, input int cnt, input logic exp_err,
                          input logic exp_nobuf, input string req);
        @(negedge clk);
        cfg_idx_kind = kind; cfg_win_base = base; cfg_win_mask = mask; cfg_miss_skip = skip;
        cfg_fill = fill; cfg_release = rel; cfg_act_ch = 8'(act); cfg_count = 16'(cnt);
        g_start = 1'b1;
        m_kind = kind; m_base = base; m_mask = mask; m_skip = skip; m_fill = fill;
        m_act = act; m_nobuf = exp_nobuf;
        @(negedge clk);
        g_start = 1'b0;
        check({req, " cfg_err"}, 32'(cfg_err), 32'(exp_err));
        check({req, " busy"}, 32'(busy), 32'(!exp_err));
        check({req, " no_buf_err"}, 32'(no_buf_err), 32'(exp_nobuf));
    endtask

    // one beat, checked one rising edge later against the requirement model
    task automatic beat(input logic [31:0] i0, input logic [31:0] i1, input logic [31:0] i2,
                        input logic [31:0] i3, input logic last, input string req);
        logic [31:0] raw [NCH];
        raw[0] = i0; raw[1] = i1; raw[2] = i2; raw[3] = i3;
        idx_valid = 1'b1;
        idx_data  = {i3, i2, i1, i0};
        @(negedge clk);
        idx_valid = 1'b0;
        check({req, " R9 out_valid"}, 32'(out_valid), 32'd1);
        check({req, " R9 done"}, 32'(done), 32'(last));
        for (int c = 0; c < NCH; c++) begin
            logic [31:0] n;
            logic        hit, we;
            logic [31:0] d;
            case (m_kind)
                2'd0:    n = {24'd0, raw[c][7:0]};
                2'd1:    n = {16'd0, raw[c][15:0]};
                default: n = raw[c];
            endcase
            hit = !m_nobuf && ((n & ~m_mask) == m_base);
            we  = (c < m_act) && (hit || !m_skip);
            d   = !we ? 32'd0 : (hit ? pat(c, int'(n[8:0] & m_mask[8:0])) : m_fill);
            check($sformatf("%s lane%0d we", req, c), 32'(out_we[c]), 32'(we));
            check($sformatf("%s lane%0d data", req, c), out_data[c*DW +: DW], d);
        end
        if (last) begin
            @(negedge clk);
            check({req, " R9 busy after done"}, 32'(busy), 32'd0);
        end
    endtask

    task automatic idle_beat(input string req);
        idx_valid = 1'b1;
        idx_data  = '1;
        @(negedge clk);
        idx_valid = 1'b0;
        check({req, " no output"}, 32'(out_valid), 32'd0);
        check({req, " no write"}, 32'(out_we), 32'd0);
    endtask

    task automatic t_reset();
        check("reset busy", 32'(busy), 32'd0);
        check("reset out_valid", 32'(out_valid), 32'd0);
        check("reset errors", 32'({cfg_err, no_buf_err, done}), 32'd0);
    endtask

    // R1 R2 R3 R4: 16-bit indices, fill on miss
    task automatic t_u16_fill();
        launch(2'd1, 32'h0200, 32'h01FF, 1'b0, 32'hDEAD_BEEF, 1'b0, 4, 3, 1'b0, 1'b0, "R1");
        beat(32'h0205, 32'h0300, 32'h0001_03FF, 32'h0400, 1'b0, "R2_R3_R4 b0");
        beat(32'h0000, 32'h0201, 32'h0200, 32'hFFFF_0210, 1'b0, "R2_R3_R4 b1");
        beat(32'h03FF, 32'h0600, 32'h0277, 32'h0205, 1'b1, "R2_R3_R4 b2");
    endtask

    // R6: 8-bit and 32-bit widths
    task automatic t_widths();
        launch(2'd0, 32'h0000, 32'h00FF, 1'b0, 32'h1234_5678, 1'b0, 4, 1, 1'b0, 1'b0, "R6 u8");
        beat(32'h1234_56F0, 32'hFFFF_FF01, 32'h0000_0100, 32'h0000_00FF, 1'b1, "R6 u8");
        launch(2'd2, 32'h8000_0000, 32'h01FF, 1'b0, 32'h0BAD_F00D, 1'b0, 4, 2, 1'b0, 1'b0, "R6 u32");
        beat(32'h8000_01FF, 32'h0000_01FF, 32'h8000_0000, 32'h8001_0000, 1'b0, "R6 u32 b0");
        beat(32'h8000_0123, 32'h4000_0123, 32'h8000_0100, 32'h8000_0002, 1'b1, "R6 u32 b1");
    endtask

    // R5: skip pass of a grouped gather, narrow window
    task automatic t_skip();
        launch(2'd1, 32'h0040, 32'h003F, 1'b1, 32'h0, 1'b0, 4, 2, 1'b0, 1'b0, "R5");
        beat(32'h0041, 32'h0000, 32'h007F, 32'h0080, 1'b0, "R5 b0");
        beat(32'h0100, 32'h0050, 32'h0001, 32'h0063, 1'b1, "R5 b1");
    endtask

    // R6 R7 R8 R12: rejected or ignored launches
    task automatic t_reject();
        launch(2'd3, 32'h0, 32'h1FF, 1'b0, 32'h0, 1'b0, 4, 1, 1'b1, 1'b0, "R6 bad kind");
        idle_beat("R6 bad kind");
        launch(2'd1, 32'h0, 32'h1FF, 1'b1, 32'h5, 1'b0, 4, 1, 1'b1, 1'b0, "R7 skip fill");
        idle_beat("R7 skip fill");
        launch(2'd1, 32'h0, 32'h1FF, 1'b0, 32'h5, 1'b0, 4, 0, 1'b1, 1'b0, "R7 zero count");
        launch(2'd1, 32'h0, 32'h1FF, 1'b0, 32'h5, 1'b0, 0, 1, 1'b1, 1'b0, "R8 zero ch");
        launch(2'd1, 32'h0, 32'h1FF, 1'b0, 32'h5, 1'b0, 5, 1, 1'b1, 1'b0, "R8 too many ch");
        // R8: partial lanes
        launch(2'd1, 32'h0, 32'h1FF, 1'b0, 32'h7777_0000, 1'b0, 2, 2, 1'b0, 1'b0, "R8 two ch");
        // R12: start while busy is ignored (cfg_err stays low, model unchanged)
        @(negedge clk);
        g_start = 1'b1; cfg_idx_kind = 2'd3;
        @(negedge clk);
        g_start = 1'b0;
        check("R12 start ignored", 32'({cfg_err, busy}), 32'b01);
        beat(32'h0003, 32'h0004, 32'h0005, 32'h0006, 1'b0, "R8 b0");
        beat(32'h0800, 32'h01FF, 32'h0005, 32'h0006, 1'b1, "R8 b1");
    endtask

    // R10 R11: release then gather without a buffer, then keep
    task automatic t_release();
        launch(2'd1, 32'h0, 32'h1FF, 1'b0, 32'h1111_2222, 1'b1, 4, 1, 1'b0, 1'b0, "R10 release");
        beat(32'h0001, 32'h0002, 32'h0003, 32'h0004, 1'b1, "R10 release");
        launch(2'd1, 32'h0, 32'h1FF, 1'b0, 32'h3333_4444, 1'b0, 4, 2, 1'b0, 1'b1, "R11 no buffer");
        beat(32'h0001, 32'h0002, 32'h0003, 32'h0004, 1'b0, "R11 b0");
        beat(32'h01FF, 32'h0000, 32'h0100, 32'h0010, 1'b1, "R11 b1");
        load_all();
        launch(2'd1, 32'h0, 32'h1FF, 1'b0, 32'h0, 1'b0, 4, 1, 1'b0, 1'b0, "R10 keep a");
        beat(32'h0011, 32'h0022, 32'h0033, 32'h0044, 1'b1, "R10 keep a");
        launch(2'd1, 32'h0, 32'h1FF, 1'b0, 32'h0, 1'b0, 4, 1, 1'b0, 1'b0, "R10 keep b");
        beat(32'h0111, 32'h0122, 32'h0133, 32'h0144, 1'b1, "R10 keep b");
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; ld_valid = 1'b0; ld_chan = '0; ld_addr = '0; ld_data = '0; ld_done = 1'b0;
        g_start = 1'b0; cfg_idx_kind = '0; cfg_win_base = '0; cfg_win_mask = '0;
        cfg_miss_skip = 1'b0; cfg_fill = '0; cfg_release = 1'b0; cfg_act_ch = '0;
        cfg_count = '0; idx_valid = 1'b0; idx_data = '0;
        m_kind = '0; m_base = '0; m_mask = '0; m_fill = '0; m_skip = 1'b0; m_nobuf = 1'b0; m_act = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        load_all();
        t_u16_fill();
        t_widths();
        t_skip();
        t_reject();
        t_release();
        finish_run();
    end

endmodule